// File: doc/BRIEF.md
# CAN transceiver wake-up controller

This block holds the digital mode and wake-up logic of a high-speed CAN line transceiver. A standby pin level picks between normal operation and a low-power standby state. In normal operation the receive-data output mirrors the sampled main bus comparator: low for dominant, high for recessive. The transmitter/receiver enable and the common-mode split reference enable are both asserted.

In standby both enables are dropped. The receive-data output then carries a filtered wake-up indication taken from the low-power bus comparator. A wake-up is reported only after the bus has stayed dominant for longer than a programmable filter window. Reporting a wake-up never leaves standby by itself. Only a low standby pin does that, and the return to normal happens after a programmable settling delay.

An elaboration parameter picks one of two wake-up variants. The unconditioned variant reports a bus that is already dominant when standby is entered. The fault-tolerant variant ignores such a dominant until the bus has been seen recessive at least once, so a shorted bus cannot hold the receive output low.

Top module: `can_wake_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, the block is in standby: `trx_en` = 0, `split_en` = 0 and `rx_out` = 1.
- R2: When `stby_pin` falls and stays low, `trx_en` and `split_en` rise exactly `MODE_DLY_CYC` + 3 clock edges after the change. This counts two synchronizer stages, one decision cycle and the settling delay.
- R3: If `stby_pin` returns high before the settling delay completes, normal mode is never entered and `trx_en` stays 0.
- R4: In normal mode `rx_out` equals the inverse of `bus_dom_main`, two clock edges after that input changes. `bus_dom_lp` has no effect on `rx_out`.
- R5: When `stby_pin` rises in normal mode, `trx_en` and `split_en` fall three clock edges later.
- R6: In standby, `bus_dom_main` has no effect on `rx_out`, and `rx_out` stays 1 while no wake-up is qualified.
- R7: `bus_dom_lp` qualifies a wake-up only when it is continuously high for more than `FILT_CYC` cycles. `rx_out` then goes low `FILT_CYC` + 3 edges after the dominant begins. Any recessive cycle before that restarts the count.
- R8: A reported wake-up is echoed for as long as the bus stays dominant. `rx_out` returns to 1 three edges after `bus_dom_lp` falls.
- R9: With `FAULT_SAFE` = 0, a dominant that is already present when standby is entered (or out of reset) is reported once the filter window has elapsed.
- R10: With `FAULT_SAFE` = 1, after standby entry or reset, no dominant is reported until `bus_dom_lp` has been sampled low at least once. After that, R7 applies.
- R11: A wake-up indication never changes the mode: `trx_en` stays 0 while `stby_pin` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_pin | input | 1 | Standby request level; 1 = standby, 0 = normal (asynchronous) |
| bus_dom_main | input | 1 | Main comparator flag; 1 = bus dominant |
| bus_dom_lp | input | 1 | Low-power comparator flag; 1 = bus dominant |
| rx_out | output | 1 | Receive data level; 0 = dominant or wake-up |
| trx_en | output | 1 | Transmitter and main receiver enable |
| split_en | output | 1 | Common-mode split reference enable |

## Verification
The bench builds two copies side by side from the same stimulus. One uses `FAULT_SAFE` = 0 and the other `FAULT_SAFE` = 1, both with `FILT_CYC` = 6 and `MODE_DLY_CYC` = 5. These short windows put the exact edge on which a wake-up or a mode change appears within a few cycles of the stimulus. The bench checks both the cycle before and the cycle of every transition. Running the two variants in parallel makes their one point of difference, a dominant bus at standby entry, visible as diverging `rx_out` values under identical inputs.

// File: rtl/can_wake_pkg.sv
package can_wake_pkg;

   typedef enum logic [1:0] {
      MS_STANDBY = 2'd0,
      MS_PEND    = 2'd1,
      MS_NORMAL  = 2'd2
   } mode_e;

   // default clock of 100 MHz: 2.5 us filter, 7.5 us settling delay
   localparam int unsigned DEF_FILT_CYC     = 250;
   localparam int unsigned DEF_MODE_DLY_CYC = 750;
   localparam int unsigned DEF_SYNC_STAGES  = 2;

endpackage

// File: rtl/can_wake_sync.sv
module can_wake_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[0] <= RST_VAL;
      else        stg_q[0] <= d_async;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg_q[s] <= RST_VAL;
         else        stg_q[s] <= stg_q[s-1];
      end
   end

   assign q_sync = stg_q[STAGES-1];

endmodule

// File: rtl/can_wake_mode.sv
module can_wake_mode
   import can_wake_pkg::*;
#(
   parameter int unsigned MODE_DLY_CYC = DEF_MODE_DLY_CYC
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stby_s,
   output logic is_normal
);

   localparam int unsigned CNT_W = $clog2(MODE_DLY_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MODE_DLY_CYC - 1);

   mode_e            state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         MS_STANDBY: begin
            cnt_d = '0;
            if (!stby_s) state_d = MS_PEND;
         end
         MS_PEND: begin
            if (stby_s) begin
               state_d = MS_STANDBY;
               cnt_d   = '0;
            end else if (cnt_q == CNT_LAST) begin
               state_d = MS_NORMAL;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         MS_NORMAL: begin
            cnt_d = '0;
            if (stby_s) state_d = MS_STANDBY;
         end
         default: begin
            state_d = MS_STANDBY;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MS_STANDBY;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign is_normal = (state_q == MS_NORMAL);

   // R2
   normal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(is_normal) |-> ($past(state_q) == MS_PEND && $past(cnt_q) == CNT_LAST));

   // R3
   pend_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MS_PEND && stby_s) |=> (state_q == MS_STANDBY));

   // R5
   standby_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_normal && stby_s) |=> !is_normal);

endmodule

// File: rtl/can_wake_filter.sv
module can_wake_filter
   import can_wake_pkg::*;
#(
   parameter int unsigned FILT_CYC   = DEF_FILT_CYC,
   parameter bit          FAULT_SAFE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic dom_s,
   output logic wake
);

   localparam int unsigned RUN_W = $clog2(FILT_CYC + 1);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(FILT_CYC);

   logic [RUN_W-1:0] run_q;
   logic             wake_q;
   logic             armed_q;

   if (FAULT_SAFE) begin : g_fault_safe
      // arming needs one recessive sample after each standby entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       armed_q <= 1'b0;
         else if (!en)     armed_q <= 1'b0;
         else if (!dom_s)  armed_q <= 1'b1;
      end

      // R10
      armed_before_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(wake_q) |-> $past(armed_q));
   end else begin : g_unconditioned
      assign armed_q = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         wake_q <= 1'b0;
      end else if (!en) begin
         run_q  <= '0;
         wake_q <= 1'b0;
      end else begin
         if (armed_q && dom_s)
            run_q <= (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
         else
            run_q <= '0;
         wake_q <= armed_q && dom_s && (run_q == RUN_MAX);
      end
   end

   assign wake = wake_q;

   // R7
   wake_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_q) |-> ($past(run_q) == RUN_MAX && $past(dom_s)));

   // R8
   echo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_q && !dom_s) |=> !wake_q);

   // R11
   no_wake_in_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !wake_q);

endmodule

// File: rtl/can_wake_ctrl.sv
module can_wake_ctrl
   import can_wake_pkg::*;
#(
   parameter int unsigned FILT_CYC     = DEF_FILT_CYC,
   parameter int unsigned MODE_DLY_CYC = DEF_MODE_DLY_CYC,
   parameter int unsigned SYNC_STAGES  = DEF_SYNC_STAGES,
   parameter bit          FAULT_SAFE   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stby_pin,
   input  logic bus_dom_main,
   input  logic bus_dom_lp,
   output logic rx_out,
   output logic trx_en,
   output logic split_en
);

   localparam int unsigned SYNC_W = 3;
   // standby and both dominant flags reset asserted
   localparam logic [SYNC_W-1:0] SYNC_RST = '1;

   if (FILT_CYC < 2) begin : g_bad_filt
      $error("FILT_CYC must be at least 2");
   end
   if (MODE_DLY_CYC < 1) begin : g_bad_dly
      $error("MODE_DLY_CYC must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_W-1:0] raw_in, sync_out;
   logic stby_s, dom_main_s, dom_lp_s;
   logic is_normal, wake;

   assign raw_in = {stby_pin, bus_dom_main, bus_dom_lp};

   can_wake_sync #(
      .WIDTH  (SYNC_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL(SYNC_RST)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async(raw_in),
      .q_sync (sync_out)
   );

   assign {stby_s, dom_main_s, dom_lp_s} = sync_out;

   can_wake_mode #(
      .MODE_DLY_CYC(MODE_DLY_CYC)
   ) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .stby_s   (stby_s),
      .is_normal(is_normal)
   );

   can_wake_filter #(
      .FILT_CYC  (FILT_CYC),
      .FAULT_SAFE(FAULT_SAFE)
   ) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (!is_normal),
      .dom_s(dom_lp_s),
      .wake (wake)
   );

   always_comb begin
      if (is_normal) rx_out = ~dom_main_s;
      else           rx_out = ~wake;
   end

   assign trx_en   = is_normal;
   assign split_en = is_normal;

   // R11
   stay_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!trx_en && stby_s) |=> !trx_en);

endmodule

// File: tb/sim_can_wake_ctrl.sv
module sim_can_wake_ctrl;

   localparam int unsigned F = 6;
   localparam int unsigned D = 5;

   typedef struct packed {
      logic       stby;
      logic       dn;
      logic       dl;
      logic [7:0] k;
      logic       rx0;
      logic       rx1;
      logic       trx;
      logic [7:0] req;
   } vec_t;

   localparam int NV = 27;
   localparam vec_t TBL [NV] = '{
      '{1'b1,1'b0,1'b0,8'd4, 1'b1,1'b1,1'b0,8'd1},   // R1 idle standby
      '{1'b1,1'b1,1'b0,8'd5, 1'b1,1'b1,1'b0,8'd6},   // R6 main flag ignored
      '{1'b1,1'b0,1'b1,8'd8, 1'b1,1'b1,1'b0,8'd7},   // R7 one short of window
      '{1'b1,1'b0,1'b1,8'd1, 1'b0,1'b0,1'b0,8'd7},   // R7 wake qualified
      '{1'b1,1'b0,1'b1,8'd10,1'b0,1'b0,1'b0,8'd11},  // R11 stays standby
      '{1'b1,1'b0,1'b0,8'd2, 1'b0,1'b0,1'b0,8'd8},   // R8 echo still low
      '{1'b1,1'b0,1'b0,8'd1, 1'b1,1'b1,1'b0,8'd8},   // R8 echo released
      '{1'b1,1'b0,1'b1,8'd6, 1'b1,1'b1,1'b0,8'd7},   // R7 short dominant
      '{1'b1,1'b0,1'b0,8'd3, 1'b1,1'b1,1'b0,8'd7},   // R7 no wake from it
      '{1'b1,1'b0,1'b1,8'd8, 1'b1,1'b1,1'b0,8'd7},   // R7 count restarted
      '{1'b1,1'b0,1'b1,8'd1, 1'b0,1'b0,1'b0,8'd7},   // R7
      '{1'b1,1'b0,1'b0,8'd3, 1'b1,1'b1,1'b0,8'd8},   // R8
      '{1'b0,1'b0,1'b0,8'd7, 1'b1,1'b1,1'b0,8'd2},   // R2 still pending
      '{1'b0,1'b0,1'b0,8'd1, 1'b1,1'b1,1'b1,8'd2},   // R2 normal entered
      '{1'b0,1'b1,1'b0,8'd1, 1'b1,1'b1,1'b1,8'd4},   // R4 latency
      '{1'b0,1'b1,1'b0,8'd1, 1'b0,1'b0,1'b1,8'd4},   // R4 dominant seen
      '{1'b0,1'b1,1'b1,8'd5, 1'b0,1'b0,1'b1,8'd4},   // R4 lp flag ignored
      '{1'b0,1'b0,1'b1,8'd2, 1'b1,1'b1,1'b1,8'd4},   // R4 recessive
      '{1'b0,1'b0,1'b0,8'd3, 1'b1,1'b1,1'b1,8'd4},   // R4
      '{1'b0,1'b1,1'b1,8'd3, 1'b0,1'b0,1'b1,8'd4},   // R4 bus dominant
      '{1'b1,1'b1,1'b1,8'd2, 1'b0,1'b0,1'b1,8'd5},   // R5 not yet left
      '{1'b1,1'b1,1'b1,8'd1, 1'b1,1'b1,1'b0,8'd5},   // R5 standby
      '{1'b1,1'b1,1'b1,8'd6, 1'b1,1'b1,1'b0,8'd9},   // R9 window running
      '{1'b1,1'b1,1'b1,8'd1, 1'b0,1'b1,1'b0,8'd9},   // R9 / R10 diverge
      '{1'b1,1'b0,1'b0,8'd3, 1'b1,1'b1,1'b0,8'd8},   // R8
      '{1'b0,1'b0,1'b0,8'd4, 1'b1,1'b1,1'b0,8'd3},   // R3 pending
      '{1'b1,1'b0,1'b0,8'd8, 1'b1,1'b1,1'b0,8'd3}    // R3 aborted
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stby = 1'b1, dn = 1'b0, dl = 1'b0;
   logic rx0, trx0, spl0, rx1, trx1, spl1;
   int   checks = 0, errors = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   can_wake_ctrl #(.FILT_CYC(F), .MODE_DLY_CYC(D), .FAULT_SAFE(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .stby_pin(stby), .bus_dom_main(dn),
      .bus_dom_lp(dl), .rx_out(rx0), .trx_en(trx0), .split_en(spl0));

   can_wake_ctrl #(.FILT_CYC(F), .MODE_DLY_CYC(D), .FAULT_SAFE(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .stby_pin(stby), .bus_dom_main(dn),
      .bus_dom_lp(dl), .rx_out(rx1), .trx_en(trx1), .split_en(spl1));

   task automatic chk(input logic act, input logic exp, input int req, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
      end
   endtask

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog (all requirements) actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1 during reset
      hold(3);
      chk(rx0, 1'b1, 1, "u0 rx in reset");
      chk(trx0, 1'b0, 1, "u0 trx in reset");
      chk(spl1, 1'b0, 1, "u1 split in reset");
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         stby = TBL[i].stby;
         dn   = TBL[i].dn;
         dl   = TBL[i].dl;
         hold(int'(TBL[i].k));
         chk(rx0,  TBL[i].rx0, int'(TBL[i].req), $sformatf("vec %0d u0 rx", i));
         chk(rx1,  TBL[i].rx1, int'(TBL[i].req), $sformatf("vec %0d u1 rx", i));
         chk(trx0, TBL[i].trx, int'(TBL[i].req), $sformatf("vec %0d u0 trx", i));
         chk(spl0, TBL[i].trx, int'(TBL[i].req), $sformatf("vec %0d u0 split", i));
         chk(trx1, TBL[i].trx, int'(TBL[i].req), $sformatf("vec %0d u1 trx", i));
         chk(spl1, TBL[i].trx, int'(TBL[i].req), $sformatf("vec %0d u1 split", i));
      end

      // R10: fault-safe copy armed by the recessive phase, now wakes normally
      dl = 1'b1;
      hold(F + 2);
      chk(rx1, 1'b1, 10, "u1 before window after arming");
      hold(1);
      chk(rx1, 1'b0, 10, "u1 wake after arming");
      chk(rx0, 1'b0, 7, "u0 wake");
      dl = 1'b0;
      hold(3);
      chk(rx1, 1'b1, 8, "u1 echo released");

      // R1 / R9 / R10: reset with bus held dominant
      dl = 1'b1;
      @(negedge clk);
      rst_n = 1'b0;
      hold(2);
      chk(rx0, 1'b1, 1, "u0 rx in second reset");
      chk(trx1, 1'b0, 1, "u1 trx in second reset");
      rst_n = 1'b1;
      hold(F);
      chk(rx0, 1'b1, 9, "u0 window after reset");
      hold(1);
      chk(rx0, 1'b0, 9, "u0 dominant-at-entry reported");
      hold(5);
      chk(rx1, 1'b1, 10, "u1 dominant-at-entry suppressed");
      chk(trx0, 1'b0, 11, "u0 remains standby while waking");
      dl = 1'b0;
      hold(3);
      dl = 1'b1;
      hold(F + 3);
      chk(rx1, 1'b0, 10, "u1 wake after recessive phase");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule